// File: doc/BRIEF.md
# Burst-Mode Dual-Address DMA Channel Sequencer

This block drives one DMA channel that moves data in burst mode with separate source and destination addresses. Once the channel is enabled and holds a nonzero unit count, it requests the bus. After the grant it runs transfer units back to back, each a one-cycle read from the source followed by a one-cycle write of that data to the destination. It keeps the bus until the count is used up. After the write that takes the count to zero it holds the bus for one idle dead cycle, releases it and raises a done flag.

A non-maskable abort input clears the channel enable. If a non-final unit is in progress, that unit finishes, the bus is dropped at once with no dead cycle, and the count and addresses are frozen. Setting the enable again resumes the transfer from where it stopped. If the final unit has already begun, the transfer runs to its normal end. Requests from higher-priority channels are passed on only while this channel is idle. Such requests also keep the channel from starting, but they cannot break into a burst that is already running.

Top module: `burst_xfer_seq`

## Requirements
- R1: After reset, bus_req, rd_stb, wr_stb, tend, ch_en and done are 0 and cur_cnt is 0.
- R2: Each unit is one cycle with rd_stb at the source address, then one cycle with wr_stb at the destination address carrying the data read. Units follow each other with bus_req held high, so a burst of N units keeps bus_req high for 2N+2 cycles (one request cycle, 2N transfer cycles, one dead cycle).
- R3: After every write, cur_src and cur_dst advance by 1 when ld_word was 0 (byte) or by 2 when ld_word was 1 (word), and cur_cnt drops by 1.
- R4: After the write that takes cur_cnt to zero, there is exactly one cycle with bus_req high and no strobe. bus_req then falls and done goes to 1.
- R5: tend is 1 during the read and write cycles of the final unit (cur_cnt equal to 1) when ld_tend_oe was 1, and is never 1 when it was 0.
- R6: hi_gnt equals hi_req while the channel is idle and is all zero while bus_req is high. While any hi_req bit is 1, an idle channel does not raise bus_req. A started burst runs all its units whatever hi_req does.
- R7: An abort_i pulse clears ch_en one cycle later, and abort wins over en_set.
- R8: An abort during a non-final unit lets that unit's write complete. bus_req falls right after that write with no dead cycle, done stays 0, and cur_cnt, cur_src and cur_dst hold.
- R9: Setting en_set after a suspension resumes the burst at the held addresses and completes the remaining units.
- R10: An abort during the read or write of the final unit still completes that unit, the dead cycle and done, and leaves ch_en at 0.
- R11: done stays 1 until a done_clr pulse clears it.
- R12: ld_stb is ignored while the channel is not idle, and the burst finishes with the count and addresses it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_stb | input | 1 | Load source, destination, count, size and end-strobe enable |
| ld_src | input | AW | Source start address |
| ld_dst | input | AW | Destination start address |
| ld_cnt | input | CW | Number of units |
| ld_word | input | 1 | 1 = word units, 0 = byte units |
| ld_tend_oe | input | 1 | Enable for the transfer-end strobe |
| en_set | input | 1 | Set the channel enable |
| abort_i | input | 1 | Non-maskable abort |
| done_clr | input | 1 | Clear the done flag |
| hi_req | input | NHI | Higher-priority channel requests |
| hi_gnt | output | NHI | Requests passed on while this channel is idle |
| bus_req | output | 1 | Bus request, held for the whole burst |
| bus_gnt | input | 1 | Bus grant |
| rd_stb | output | 1 | Read cycle strobe |
| wr_stb | output | 1 | Write cycle strobe |
| bus_addr | output | AW | Address of the current cycle |
| bus_word | output | 1 | Size of the current cycle |
| rdata | input | DW | Read data |
| wdata | output | DW | Write data |
| tend | output | 1 | Transfer-end strobe |
| ch_en | output | 1 | Channel enable state |
| done | output | 1 | Transfer complete flag |
| cur_src | output | AW | Current source address |
| cur_dst | output | AW | Current destination address |
| cur_cnt | output | CW | Units remaining |

## Verification
The bench builds the block with 16-bit addresses and data, an 8-bit count and two higher-priority request lines. These sizes are enough to run byte and word bursts of several units, so the 1- and 2-step address advance can be checked. Because the bus grant follows the request at once, the request-cycle count of each burst is exact. Aborts are placed on the read cycle of a chosen unit, using the visible count, to reach both the mid-burst suspend with a later resume and the final-unit completion.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_RD   = 3'd2,
    ST_WR   = 3'd3,
    ST_DEAD = 3'd4
  } seq_state_t;
endpackage

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          step,
  input  logic          word,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] STEP_B = AW'(1);
  localparam logic [AW-1:0] STEP_W = AW'(2);

  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (ld) begin
      addr_d = ld_val;
    end else if (step) begin
      addr_d = addr_q + (word ? STEP_W : STEP_B);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (ld || step) begin
      addr_q <= addr_d;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/dma_unit_ctr.sv
module dma_unit_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          is_last,
  output logic          nonzero
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ld) begin
      cnt_d = ld_val;
    end else if (dec) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ld || dec) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt     = cnt_q;
  assign is_last = (cnt_q == ONE);
  assign nonzero = |cnt_q;
endmodule

// File: rtl/dma_burst_fsm.sv
module dma_burst_fsm
  import dma_burst_pkg::*;
#(
  parameter int NHI = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_q,
  input  logic           abort_i,
  input  logic           cnt_nz,
  input  logic           is_last,
  input  logic [NHI-1:0] hi_req,
  input  logic           bus_gnt,
  output logic           idle,
  output logic           bus_req,
  output logic           rd,
  output logic           wr,
  output logic           dead
);
  seq_state_t st_q, st_d;
  logic       go_on;

  assign go_on = en_q && !abort_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (go_on && cnt_nz && !(|hi_req)) st_d = ST_REQ;
      ST_REQ: begin
        if (!go_on)       st_d = ST_IDLE;
        else if (bus_gnt) st_d = ST_RD;
      end
      ST_RD: st_d = ST_WR;
      ST_WR: begin
        if (is_last)    st_d = ST_DEAD;
        else if (go_on) st_d = ST_RD;
        else            st_d = ST_IDLE;
      end
      ST_DEAD: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign idle    = (st_q == ST_IDLE);
  assign bus_req = !idle;
  assign rd      = (st_q == ST_RD);
  assign wr      = (st_q == ST_WR);
  assign dead    = (st_q == ST_DEAD);
endmodule

// File: rtl/dma_chan_flags.sv
module dma_chan_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic en_set,
  input  logic abort_i,
  input  logic done_set,
  input  logic done_clr,
  output logic en_q,
  output logic done_q
);
  logic en_r, en_d, done_r, done_d;

  always_comb begin
    en_d = en_r;
    if (abort_i)     en_d = 1'b0;
    else if (en_set) en_d = 1'b1;
    done_d = done_r;
    if (done_set)      done_d = 1'b1;
    else if (done_clr) done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r   <= 1'b0;
      done_r <= 1'b0;
    end else begin
      en_r   <= en_d;
      done_r <= done_d;
    end
  end

  assign en_q   = en_r;
  assign done_q = done_r;
endmodule

// File: rtl/burst_xfer_seq.sv
module burst_xfer_seq #(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int CW  = 8,
  parameter int NHI = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_stb,
  input  logic [AW-1:0]  ld_src,
  input  logic [AW-1:0]  ld_dst,
  input  logic [CW-1:0]  ld_cnt,
  input  logic           ld_word,
  input  logic           ld_tend_oe,
  input  logic           en_set,
  input  logic           abort_i,
  input  logic           done_clr,
  input  logic [NHI-1:0] hi_req,
  output logic [NHI-1:0] hi_gnt,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic           rd_stb,
  output logic           wr_stb,
  output logic [AW-1:0]  bus_addr,
  output logic           bus_word,
  input  logic [DW-1:0]  rdata,
  output logic [DW-1:0]  wdata,
  output logic           tend,
  output logic           ch_en,
  output logic           done,
  output logic [AW-1:0]  cur_src,
  output logic [AW-1:0]  cur_dst,
  output logic [CW-1:0]  cur_cnt
);
  localparam int NPTR = 2;

  // reset: asserted at once, released through two flops
  logic rst_s1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  logic idle, rd, wr, dead, en_q, done_q, is_last, cnt_nz, ld_ok;
  logic word_q, toe_q, word_d, toe_d;
  logic [DW-1:0] data_q, data_d;
  logic [NPTR-1:0][AW-1:0] ptr_ld, ptr_val;

  assign ld_ok = ld_stb && idle;

  dma_chan_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en_set   (en_set),
    .abort_i  (abort_i),
    .done_set (dead),
    .done_clr (done_clr),
    .en_q     (en_q),
    .done_q   (done_q)
  );

  dma_burst_fsm #(.NHI(NHI)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en_q    (en_q),
    .abort_i (abort_i),
    .cnt_nz  (cnt_nz),
    .is_last (is_last),
    .hi_req  (hi_req),
    .bus_gnt (bus_gnt),
    .idle    (idle),
    .bus_req (bus_req),
    .rd      (rd),
    .wr      (wr),
    .dead    (dead)
  );

  dma_unit_ctr #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ld      (ld_ok),
    .ld_val  (ld_cnt),
    .dec     (wr),
    .cnt     (cur_cnt),
    .is_last (is_last),
    .nonzero (cnt_nz)
  );

  assign ptr_ld[0] = ld_src;
  assign ptr_ld[1] = ld_dst;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dma_addr_reg #(.AW(AW)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .ld     (ld_ok),
      .ld_val (ptr_ld[g]),
      .step   (wr),
      .word   (word_q),
      .addr   (ptr_val[g])
    );
  end

  assign cur_src = ptr_val[0];
  assign cur_dst = ptr_val[1];

  always_comb begin
    word_d = ld_ok ? ld_word : word_q;
    toe_d  = ld_ok ? ld_tend_oe : toe_q;
    data_d = rd ? rdata : data_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      word_q <= 1'b0;
      toe_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (ld_ok) begin
        word_q <= word_d;
        toe_q  <= toe_d;
      end
      if (rd) data_q <= data_d;
    end
  end

  assign rd_stb   = rd;
  assign wr_stb   = wr;
  assign bus_addr = wr ? cur_dst : cur_src;
  assign bus_word = word_q;
  assign wdata    = data_q;
  assign tend     = toe_q && is_last && (rd || wr);
  assign hi_gnt   = hi_req & {NHI{idle}};
  assign ch_en    = en_q;
  assign done     = done_q;
endmodule

// File: rtl/dma_burst_seq_chk.sv
module dma_burst_seq_chk #(
  parameter int CW  = 8,
  parameter int NHI = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           abort_i,
  input logic           done_clr,
  input logic [NHI-1:0] hi_gnt,
  input logic           bus_req,
  input logic           rd_stb,
  input logic           wr_stb,
  input logic           tend,
  input logic           ch_en,
  input logic           done,
  input logic [CW-1:0]  cur_cnt
);
  localparam logic [CW-1:0] ONE = CW'(1);

  p_rd_then_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> wr_stb);

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (cur_cnt == $past(cur_cnt) - ONE));

  p_dead_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && cur_cnt == ONE) |=> (bus_req && !rd_stb && !wr_stb));

  p_release_after_dead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_stb) && bus_req && !rd_stb && !wr_stb) |=> !bus_req);

  p_tend_final_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tend |-> (cur_cnt == ONE && (rd_stb || wr_stb)));

  p_no_pass_in_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (hi_gnt == '0));

  p_abort_disables_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !ch_en);

  p_suspend_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && cur_cnt != ONE && (!ch_en || abort_i)) |=> !bus_req);

  p_done_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_clr) |=> done);
endmodule

bind burst_xfer_seq dma_burst_seq_chk #(.CW(CW), .NHI(NHI)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .abort_i  (abort_i),
  .done_clr (done_clr),
  .hi_gnt   (hi_gnt),
  .bus_req  (bus_req),
  .rd_stb   (rd_stb),
  .wr_stb   (wr_stb),
  .tend     (tend),
  .ch_en    (ch_en),
  .done     (done),
  .cur_cnt  (cur_cnt)
);

// File: tb/burst_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module burst_xfer_seq_tb_top;
  localparam int AW = 16, DW = 16, CW = 8, NHI = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic ld_stb, ld_word, ld_tend_oe, en_set, abort_i, done_clr;
  logic [AW-1:0] ld_src, ld_dst;
  logic [CW-1:0] ld_cnt;
  logic [NHI-1:0] hi_req, hi_gnt;
  logic bus_req, bus_gnt, rd_stb, wr_stb, bus_word, tend, ch_en, done;
  logic [AW-1:0] bus_addr, cur_src, cur_dst;
  logic [DW-1:0] rdata, wdata;
  logic [CW-1:0] cur_cnt;

  always #4 clk = ~clk;

  assign bus_gnt = bus_req;
  assign rdata   = bus_addr ^ 16'h5A3C;

  burst_xfer_seq #(.AW(AW), .DW(DW), .CW(CW), .NHI(NHI)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  int m_rd = 0, m_wr = 0, m_dead = 0, m_rel = 0, m_req = 0, m_tend = 0;
  int m_derr = 0, m_hiv = 0;
  logic [AW-1:0] wa_log [0:255];
  logic [AW-1:0] last_ra = '0;
  logic prev_wr = 1'b0;
  int b_rd, b_wr, b_dead, b_rel, b_req, b_tend, b_derr, b_hiv;

  // bus monitor, sampled 2 ns after each rising edge
  always begin
    @(posedge clk);
    #2;
    if (rst_n) begin
      if (bus_req) m_req++;
      if (tend) m_tend++;
      if (bus_req && hi_gnt != '0) m_hiv++;
      if (rd_stb) begin
        m_rd++;
        last_ra = bus_addr;
      end
      if (wr_stb) begin
        if (wdata != (last_ra ^ 16'h5A3C)) m_derr++;
        wa_log[m_wr & 255] = bus_addr;
        m_wr++;
      end
      if (prev_wr && !wr_stb && !rd_stb) begin
        if (bus_req) m_dead++;
        else m_rel++;
      end
      prev_wr = wr_stb;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic snap();
    b_rd = m_rd; b_wr = m_wr; b_dead = m_dead; b_rel = m_rel;
    b_req = m_req; b_tend = m_tend; b_derr = m_derr; b_hiv = m_hiv;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [AW-1:0] s, input logic [AW-1:0] d,
                      input logic [CW-1:0] c, input logic w, input logic oe);
    @(negedge clk);
    ld_src = s; ld_dst = d; ld_cnt = c; ld_word = w; ld_tend_oe = oe;
    ld_stb = 1'b1;
    @(negedge clk);
    ld_stb = 1'b0;
  endtask

  task automatic pulse_en();
    @(negedge clk); en_set = 1'b1;
    @(negedge clk); en_set = 1'b0;
  endtask

  task automatic wait_burst();
    for (int i = 0; i < 30 && !bus_req; i++) @(negedge clk);
    for (int i = 0; i < 600 && bus_req; i++) @(negedge clk);
    tick(2);
  endtask

  task automatic t_reset();
    chk("R1 bus_req", bus_req, 0);
    chk("R1 strobes", {rd_stb, wr_stb, tend}, 0);
    chk("R1 ch_en", ch_en, 0);
    chk("R1 done", done, 0);
    chk("R1 cur_cnt", cur_cnt, 0);
  endtask

  task automatic t_byte_burst();
    load(16'h0100, 16'h0200, 8'd4, 1'b0, 1'b1);
    snap();
    pulse_en();
    wait_burst();
    chk("R2 writes", m_wr - b_wr, 4);
    chk("R2 reads", m_rd - b_rd, 4);
    chk("R2 write data", m_derr - b_derr, 0);
    chk("R2 bus hold cycles", m_req - b_req, 10);
    chk("R4 dead cycles", m_dead - b_dead, 1);
    chk("R4 release without dead", m_rel - b_rel, 0);
    chk("R4 done", done, 1);
    chk("R5 tend cycles", m_tend - b_tend, 2);
    chk("R3 byte src", cur_src, 16'h0104);
    chk("R3 byte dst", cur_dst, 16'h0204);
    chk("R3 last write addr", wa_log[(m_wr - 1) & 255], 16'h0203);
    chk("R3 count", cur_cnt, 0);
    tick(5);
    chk("R11 done held", done, 1);
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
    chk("R11 done cleared", done, 0);
  endtask

  task automatic t_word_burst();
    snap();
    load(16'h1000, 16'h3000, 8'd3, 1'b1, 1'b0);
    wait_burst();
    chk("R3 word writes", m_wr - b_wr, 3);
    chk("R3 word src", cur_src, 16'h1006);
    chk("R3 word dst", cur_dst, 16'h3006);
    chk("R3 word last addr", wa_log[(m_wr - 1) & 255], 16'h3004);
    chk("R5 tend off", m_tend - b_tend, 0);
    chk("R2 word hold cycles", m_req - b_req, 8);
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
  endtask

  task automatic t_hipri();
    @(negedge clk); abort_i = 1'b1; en_set = 1'b1;
    @(negedge clk); abort_i = 1'b0; en_set = 1'b0;
    chk("R7 abort beats set", ch_en, 0);
    hi_req = 2'b01;
    load(16'h0040, 16'h0080, 8'd5, 1'b0, 1'b0);
    snap();
    pulse_en();
    tick(6);
    chk("R6 held off", bus_req, 0);
    chk("R6 pass through idle", hi_gnt, 2'b01);
    hi_req = 2'b00;
    for (int i = 0; i < 20 && !bus_req; i++) @(negedge clk);
    tick(2);
    hi_req = 2'b11;
    for (int i = 0; i < 600 && bus_req; i++) @(negedge clk);
    tick(2);
    chk("R6 burst not preempted", m_wr - b_wr, 5);
    chk("R6 no grant in burst", m_hiv - b_hiv, 0);
    chk("R6 grant after release", hi_gnt, 2'b11);
    hi_req = 2'b00;
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
  endtask

  task automatic t_load_ignored();
    snap();
    load(16'h0400, 16'h0480, 8'd6, 1'b0, 1'b0);
    for (int i = 0; i < 30 && !wr_stb; i++) @(negedge clk);
    ld_src = 16'h0999; ld_dst = 16'h0777; ld_cnt = 8'h30; ld_word = 1'b1;
    ld_stb = 1'b1;
    @(negedge clk);
    ld_stb = 1'b0;
    wait_burst();
    chk("R12 writes unchanged", m_wr - b_wr, 6);
    chk("R12 src unchanged", cur_src, 16'h0406);
    chk("R12 dst unchanged", cur_dst, 16'h0486);
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
  endtask

  task automatic t_abort_mid();
    snap();
    load(16'h0500, 16'h0600, 8'd6, 1'b0, 1'b1);
    for (int i = 0; i < 60 && !(rd_stb && cur_cnt == 8'd4); i++) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    chk("R7 enable cleared", ch_en, 0);
    for (int i = 0; i < 20 && bus_req; i++) @(negedge clk);
    tick(5);
    chk("R8 unit completed", m_wr - b_wr, 3);
    chk("R8 no dead cycle", m_dead - b_dead, 0);
    chk("R8 bus released", m_rel - b_rel, 1);
    chk("R8 still released", bus_req, 0);
    chk("R8 done stays 0", done, 0);
    chk("R8 count held", cur_cnt, 3);
    chk("R8 src held", cur_src, 16'h0503);
    chk("R8 tend silent", m_tend - b_tend, 0);
    snap();
    pulse_en();
    wait_burst();
    chk("R9 remaining units", m_wr - b_wr, 3);
    chk("R9 resume addr", wa_log[b_wr & 255], 16'h0603);
    chk("R9 src final", cur_src, 16'h0506);
    chk("R9 dead once", m_dead - b_dead, 1);
    chk("R9 done", done, 1);
    chk("R5 tend on resume", m_tend - b_tend, 2);
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
  endtask

  task automatic t_abort_last();
    snap();
    load(16'h0700, 16'h0800, 8'd2, 1'b0, 1'b0);
    for (int i = 0; i < 60 && !(rd_stb && cur_cnt == 8'd1); i++) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    wait_burst();
    chk("R10 all units", m_wr - b_wr, 2);
    chk("R10 dead cycle", m_dead - b_dead, 1);
    chk("R10 done", done, 1);
    chk("R10 count zero", cur_cnt, 0);
    chk("R10 enable off", ch_en, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    ld_stb = 1'b0; ld_word = 1'b0; ld_tend_oe = 1'b0; en_set = 1'b0;
    abort_i = 1'b0; done_clr = 1'b0; hi_req = '0;
    ld_src = '0; ld_dst = '0; ld_cnt = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    fork
      begin
        t_reset();
        t_byte_burst();
        t_word_burst();
        t_hipri();
        t_load_ignored();
        t_abort_mid();
        t_abort_last();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule